// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This core moves 8-bit, 64 kb/s channels between a set of serial TDM input streams and the same number of serial TDM output streams. Each stream carries 32 channels, one bit per clock, most significant bit first. A single frame pulse marks the first bit of channel 0. The serial inputs are turned into bytes and written into a two-bank data memory. For each output channel, a connect memory entry decides what is sent. The entry either names an input stream and channel (a switched connection) or holds a fixed byte written by the CPU (a message).

Each output channel also has its own settings for latency mode, line drive and a control-stream bit. A global drive-enable input overrides every per-channel drive bit. The CPU reaches the connect memory through a small write/read port. A page register supplies the upper address bits: it picks the stream and whether the low or the high part of the entry is accessed. The port address supplies the channel number.

Top module: `tsi_switch`

## Requirements
- R1: After reset, and until the first `frm_i` pulse, `ser_oe`, `ser_out` and `ctl_out` are all zero. After reset every connect memory entry reads 0 and the page register reads 0.
- R2: When bit 0 of an output channel's high entry is 1 (message), that channel sends its low-entry byte in every frame, MSB first, until the CPU rewrites it.
- R3: When bit 0 of the high entry is 0 (connection), low-entry bits [4:0] give the source channel and bits [6:5] give the source stream; bit 7 is ignored. Any number of outputs may name the same source.
- R4: When bit 2 of the high entry is 0 (constant delay), output slot j of frame G carries that source's byte from input frame G-1.
- R5: When bit 2 of the high entry is 1 (variable delay), output slot j of frame G carries the source's byte from frame G if the source channel is below j, and from frame G-1 otherwise.
- R6: Position 0 is the cycle in which `frm_i` is high, and positions run 0 to 255. Output slot j occupies positions 8j to 8j+7, and bit 1 of the high entry enables the drive for that slot. When `ser_oe` is low, `ser_out` is 0.
- R7: While `ode_i` is low, every `ser_oe` bit is low in the same cycle, whatever the per-channel bits are.
- R8: Bit 3 of the high entry appears on that stream's `ctl_out` for the whole of the slot.
- R9: An address with bit 5 set selects the page register. Its bits [1:0] pick the stream and its bit 2 picks the high part (1) or the low part (0). An address with bit 5 clear selects channel [4:0] on the current page. Reads are combinational, and writes take effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_i | input | 1 | Frame pulse, high during position 0 |
| ser_in | input | NS | Serial input streams |
| ode_i | input | 1 | Global output drive enable |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 6 | CPU address (page register or channel) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| ser_out | output | NS | Serial output streams |
| ser_oe | output | NS | Per-stream drive enable for the current bit |
| ctl_out | output | NS | Control-stream bit for the current slot |

## Verification
A wrong bank choice or a missing same-cycle bypass does not crash anything. It shows up as an output byte that is exactly one frame stale or one frame early, and only for the source/destination channel pairs at the boundary, where the source channel equals or is just below the destination slot. A corrupted connect entry appears on the very next slot that uses it: it carries the wrong byte, drive or control bit, and it repeats every frame. A slot-alignment error shifts every output bit by whole positions, so every frame fails. For these reasons the reference model is compared bit by bit on every clock, and the source mappings are chosen to straddle the slot boundary.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;

  // Per-output-channel control bits: [3] ctl, [2] variable delay, [1] drive, [0] message
  typedef struct packed {
    logic ctl;
    logic var_dly;
    logic drive;
    logic msg;
  } cmh_t;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int NCH = 32,
  localparam int CW = $clog2(NCH),
  localparam int PW = CW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_i,
  output logic          bank,
  output logic          synced,
  output logic          byte_end,
  output logic          slot_first,
  output logic [CW-1:0] slot,
  output logic [CW-1:0] nxt_slot
);
  localparam logic [PW-1:0] LAST = PW'(NCH * 8 - 1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          bank_q, bank_d;
  logic          sync_q, sync_d;

  always_comb begin
    cnt_d  = (frm_i || cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    bank_d = (cnt_d == '0) ? ~bank_q : bank_q;
    sync_d = sync_q | frm_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bank_q <= bank_d;
      sync_q <= sync_d;
    end
  end

  assign bank       = bank_d;
  assign synced     = sync_d;
  assign slot       = cnt_d[PW-1:3];
  assign slot_first = (cnt_d[2:0] == 3'd0);
  assign byte_end   = sync_d && (cnt_d[2:0] == 3'd7);
  assign nxt_slot   = (slot == CW'(NCH - 1)) ? '0 : slot + 1'b1;
endmodule

// File: rtl/tsi_inbuf.sv
module tsi_inbuf #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NS-1:0]         ser_in,
  input  logic                  byte_end,
  input  logic                  bank,
  input  logic [CW-1:0]         slot,
  input  logic [NS-1:0]         rd_bank,
  input  logic [NS-1:0][SW-1:0] rd_stream,
  input  logic [NS-1:0][CW-1:0] rd_ch,
  output logic [NS-1:0][7:0]    rd_data
);
  logic [NS-1:0][6:0] sh_q, sh_d;
  logic [7:0]         mem [2][NS][NCH];

  always_comb begin
    for (int s = 0; s < NS; s++) sh_d[s] = {sh_q[s][5:0], ser_in[s]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // Byte write at the last bit of each slot; the active bank holds the frame in progress
  always_ff @(posedge clk) begin
    if (byte_end) begin
      for (int s = 0; s < NS; s++) mem[bank][s][slot] <= {sh_q[s], ser_in[s]};
    end
  end

  for (genvar r = 0; r < NS; r++) begin : g_rd
    logic hit;
    // A byte completing this very cycle is forwarded before it reaches the array
    assign hit = byte_end && (rd_bank[r] == bank) && (rd_ch[r] == slot);
    assign rd_data[r] = hit ? {sh_q[rd_stream[r]], ser_in[rd_stream[r]]}
                            : mem[rd_bank[r]][rd_stream[r]][rd_ch[r]];
  end
endmodule

// File: rtl/tsi_connmem.sv
module tsi_connmem #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NCH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_we,
  input  logic [CW:0]                cpu_addr,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  input  logic [CW-1:0]              rd_ch,
  output logic [NS-1:0][7:0]         lo_out,
  output tsi_pkg::cmh_t [NS-1:0]     hi_out
);
  logic [SW:0]   page_q, page_d;
  logic [7:0]    lo_q [NS][NCH];
  logic [3:0]    hi_q [NS][NCH];
  logic          sel_page, pg_hi;
  logic [SW-1:0] pg_st;
  logic [CW-1:0] ch;

  assign sel_page = cpu_addr[CW];
  assign ch       = cpu_addr[CW-1:0];
  assign pg_hi    = page_q[SW];
  assign pg_st    = page_q[SW-1:0];

  always_comb begin
    page_d = (cpu_we && sel_page) ? cpu_wdata[SW:0] : page_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        for (int c = 0; c < NCH; c++) begin
          lo_q[s][c] <= '0;
          hi_q[s][c] <= '0;
        end
      end
    end else if (cpu_we && !sel_page) begin
      if (pg_hi) hi_q[pg_st][ch] <= cpu_wdata[3:0];
      else       lo_q[pg_st][ch] <= cpu_wdata;
    end
  end

  always_comb begin
    if (sel_page)   cpu_rdata = 8'(page_q);
    else if (pg_hi) cpu_rdata = {4'b0000, hi_q[pg_st][ch]};
    else            cpu_rdata = lo_q[pg_st][ch];
  end

  for (genvar s = 0; s < NS; s++) begin : g_rd
    assign lo_out[s] = lo_q[s][rd_ch];
    assign hi_out[s] = tsi_pkg::cmh_t'(hi_q[s][rd_ch]);
  end
endmodule

// File: rtl/tsi_outser.sv
module tsi_outser #(
  parameter int NS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               ode_i,
  input  logic [NS-1:0][7:0] byte_in,
  input  logic [NS-1:0]      drive_in,
  input  logic [NS-1:0]      ctl_in,
  output logic [NS-1:0]      ser_out,
  output logic [NS-1:0]      ser_oe,
  output logic [NS-1:0]      ctl_out
);
  logic [NS-1:0][7:0] sh_q, sh_d;
  logic [NS-1:0]      oe_q, oe_d, ctl_q, ctl_d;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      if (load) begin
        sh_d[s]  = byte_in[s];
        oe_d[s]  = drive_in[s];
        ctl_d[s] = ctl_in[s];
      end else begin
        sh_d[s]  = {sh_q[s][6:0], 1'b0};
        oe_d[s]  = oe_q[s];
        ctl_d[s] = ctl_q[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      oe_q  <= '0;
      ctl_q <= '0;
    end else begin
      sh_q  <= sh_d;
      oe_q  <= oe_d;
      ctl_q <= ctl_d;
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_pin
    assign ser_oe[s]  = ode_i & oe_q[s];
    assign ser_out[s] = ser_oe[s] & sh_q[s][7];
    assign ctl_out[s] = ctl_q[s];
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int NS  = 4,
  parameter int NCH = 32,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_i,
  input  logic [NS-1:0] ser_in,
  input  logic          ode_i,
  input  logic          cpu_we,
  input  logic [CW:0]   cpu_addr,
  input  logic [7:0]    cpu_wdata,
  output logic [7:0]    cpu_rdata,
  output logic [NS-1:0] ser_out,
  output logic [NS-1:0] ser_oe,
  output logic [NS-1:0] ctl_out
);
  logic [1:0] rs_q;
  logic       rst_n_sync;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_sync = rs_q[1];

  logic          bank, synced, byte_end, slot_first;
  logic [CW-1:0] slot, nxt_slot;

  tsi_timing #(.NCH(NCH)) u_tim (
    .clk(clk), .rst_n(rst_n_sync), .frm_i(frm_i), .bank(bank), .synced(synced),
    .byte_end(byte_end), .slot_first(slot_first), .slot(slot), .nxt_slot(nxt_slot)
  );

  logic [NS-1:0][7:0]     lo_rd, dm_rd, byte_sel;
  tsi_pkg::cmh_t [NS-1:0] hi_rd;
  logic [NS-1:0]          rd_bank, drive_v, ctl_v;
  logic [NS-1:0][SW-1:0]  rd_st;
  logic [NS-1:0][CW-1:0]  rd_ch;

  tsi_connmem #(.NS(NS), .NCH(NCH)) u_cm (
    .clk(clk), .rst_n(rst_n_sync), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rd_ch(nxt_slot),
    .lo_out(lo_rd), .hi_out(hi_rd)
  );

  // Source choice for the slot about to be serialised
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      logic use_cur;
      rd_ch[s] = lo_rd[s][CW-1:0];
      rd_st[s] = SW'(lo_rd[s][7:CW]);
      if (hi_rd[s].var_dly) use_cur = (rd_ch[s] <= slot);
      else                  use_cur = (slot == CW'(NCH - 1));
      rd_bank[s]  = use_cur ? bank : ~bank;
      byte_sel[s] = hi_rd[s].msg ? lo_rd[s] : dm_rd[s];
      drive_v[s]  = hi_rd[s].drive;
      ctl_v[s]    = hi_rd[s].ctl;
    end
  end

  tsi_inbuf #(.NS(NS), .NCH(NCH)) u_ib (
    .clk(clk), .rst_n(rst_n_sync), .ser_in(ser_in), .byte_end(byte_end),
    .bank(bank), .slot(slot), .rd_bank(rd_bank), .rd_stream(rd_st),
    .rd_ch(rd_ch), .rd_data(dm_rd)
  );

  tsi_outser #(.NS(NS)) u_os (
    .clk(clk), .rst_n(rst_n_sync), .load(byte_end), .ode_i(ode_i),
    .byte_in(byte_sel), .drive_in(drive_v), .ctl_in(ctl_v),
    .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
  parameter int NS = 4,
  parameter int CW = 5,
  localparam int SW = $clog2(NS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ode_i,
  input logic          synced,
  input logic          slot_first,
  input logic          cpu_we,
  input logic [CW:0]   cpu_addr,
  input logic [7:0]    cpu_wdata,
  input logic [7:0]    cpu_rdata,
  input logic [NS-1:0] ser_out,
  input logic [NS-1:0] ser_oe,
  input logic [NS-1:0] ctl_out
);
  p_idle_until_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (ser_oe == '0 && ctl_out == '0));

  p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ode_i |-> (ser_oe == '0));

  p_quiet_undriven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out & ~ser_oe) == '0);

  p_drive_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !slot_first && $stable(ode_i)) |-> $stable(ser_oe));

  p_ctl_slot_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (synced && !slot_first) |-> $stable(ctl_out));

  p_page_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr[CW]) |=> (cpu_we || !cpu_addr[CW] ||
      (cpu_rdata[SW:0] == $past(cpu_wdata[SW:0]) && cpu_rdata[7:SW+1] == '0)));
endmodule

bind tsi_switch tsi_switch_chk #(.NS(NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .ode_i(ode_i), .synced(synced),
  .slot_first(slot_first), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ser_out(ser_out),
  .ser_oe(ser_oe), .ctl_out(ctl_out)
);

// File: tb/tsi_switch_tb.sv
`timescale 1ns/1ps
module tsi_switch_tb;
  localparam int NS  = 4;
  localparam int NCH = 32;
  localparam int CW  = 5;
  localparam int FR  = NCH * 8;
  localparam logic [CW:0] PAGE = 6'h20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, frm_i, ode_i, cpu_we;
  logic [NS-1:0] ser_in;
  logic [CW:0]   cpu_addr;
  logic [7:0]    cpu_wdata;
  wire  [7:0]    cpu_rdata;
  wire  [NS-1:0] ser_out, ser_oe, ctl_out;

  tsi_switch #(.NS(NS), .NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_i(frm_i), .ser_in(ser_in), .ode_i(ode_i),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .ser_out(ser_out), .ser_oe(ser_oe), .ctl_out(ctl_out)
  );

  int   checks = 0, errors = 0;
  bit   done = 0, running = 0;
  int   q = 0, frame = 0, hold = 0;
  int   cfg_lo [NS][NCH];
  int   cfg_hi [NS][NCH];
  bit   bc     [NS][NCH];
  logic [7:0] inb [2][NS][NCH];
  logic [31:0] lf = 32'h1234_5678;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s q=%0d frame=%0d actual %0h expected %0h", tag, q, frame, act, exp);
    end
  endtask

  // One bit time: drive inputs, compare against the model, advance the model
  task automatic tick();
    int  j, b, hi, lo, sc, ss, fr;
    bit  eo, ec, ed;
    logic [7:0] dat;
    string tg;
    @(negedge clk);
    if (running) begin
      frm_i = (q == 0);
      for (int s = 0; s < NS; s++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        ser_in[s] = lf[0];
        inb[frame % 2][s][q / 8][7 - (q % 8)] = lf[0];
      end
    end else begin
      frm_i  = 1'b0;
      ser_in = '0;
    end
    #1;
    if (!running) begin
      chk(ser_oe == '0,  "R1 oe idle",  32'(ser_oe),  0);
      chk(ser_out == '0, "R1 out idle", 32'(ser_out), 0);
      chk(ctl_out == '0, "R1 ctl idle", 32'(ctl_out), 0);
    end else if (hold == 0) begin
      j = q / 8;
      b = q % 8;
      for (int s = 0; s < NS; s++) begin
        hi = cfg_hi[s][j];
        lo = cfg_lo[s][j];
        eo = ode_i && hi[1];
        ec = hi[3];
        if (hi[0]) begin
          dat = 8'(lo);
          tg  = "R2 message data";
        end else begin
          sc  = lo % NCH;
          ss  = (lo / NCH) % NS;
          fr  = (hi[2] && sc < j) ? frame : frame - 1;
          dat = inb[fr % 2][ss][sc];
          tg  = bc[s][j] ? "R3 broadcast data" : (hi[2] ? "R5 variable data" : "R4 constant data");
        end
        ed = eo && dat[7 - b];
        chk(ser_out[s] == ed, tg, 32'(ser_out[s]), 32'(ed));
        chk(ser_oe[s] == eo, ode_i ? "R6 slot drive" : "R7 global off", 32'(ser_oe[s]), 32'(eo));
        chk(ctl_out[s] == ec, "R8 control bit", 32'(ctl_out[s]), 32'(ec));
      end
    end
    if (running) begin
      if (hold > 0) hold--;
      q++;
      if (q == FR) begin
        q = 0;
        frame++;
      end
    end
  endtask

  task automatic cpu_wr(input logic [CW:0] a, input logic [7:0] d);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_we    = 1'b1;
    tick();
    cpu_we    = 1'b0;
  endtask

  task automatic rd_chk(input logic [CW:0] a, input logic [7:0] exp, input string tag);
    cpu_addr = a;
    #1;
    chk(cpu_rdata == exp, tag, 32'(cpu_rdata), 32'(exp));
  endtask

  task automatic push_cfg();
    hold = 1 << 30;
    for (int s = 0; s < NS; s++) begin
      cpu_wr(PAGE, 8'(s));
      for (int c = 0; c < NCH; c++) cpu_wr(6'(c), 8'(cfg_lo[s][c]));
      cpu_wr(PAGE, 8'(4 + s));
      for (int c = 0; c < NCH; c++) cpu_wr(6'(c), 8'(cfg_hi[s][c]));
    end
    hold = 2 * FR;
  endtask

  initial begin
    rst_n = 1'b0; frm_i = 1'b0; ode_i = 1'b1; cpu_we = 1'b0;
    ser_in = '0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1: reset contents through the CPU port
    rd_chk(PAGE, 8'h00, "R1 page reg reset");
    rd_chk(6'd0, 8'h00, "R1 low entry reset");
    cpu_wr(PAGE, 8'h04);
    rd_chk(6'd5, 8'h00, "R1 high entry reset");
    rd_chk(PAGE, 8'h04, "R9 page readback");
    repeat (20) tick();

    // Config A: mixed modes; R3 broadcast group; bit 7 set on odd channels must be ignored
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < NCH; j++) begin
        bit m, dr, v, ct;
        m  = (j % 7 == 2);
        dr = (j % 5 != 3);
        v  = (j % 2 == 1);
        ct = (j % 3 == 0);
        cfg_hi[s][j] = {28'd0, ct, v, dr, m};
        bc[s][j] = 1'b0;
        if (m) cfg_lo[s][j] = (j * 9 + s * 17) % 256;
        else   cfg_lo[s][j] = ((s + 1) % NS) * NCH + (NCH - 1 - j) + ((j % 2 == 1) ? 128 : 0);
      end
    end
    for (int j = 10; j < 14; j++) begin
      cfg_lo[0][j] = 2 * NCH + 5;
      bc[0][j] = 1'b1;
    end
    push_cfg();
    running = 1'b1;
    repeat (4 * FR) tick();

    // R9: readback of stored entries through the page register
    cpu_wr(PAGE, 8'h05);
    rd_chk(PAGE, 8'h05, "R9 page high s1");
    rd_chk(6'd3, 8'(cfg_hi[1][3]), "R9 high entry s1 c3");
    cpu_wr(PAGE, 8'h02);
    rd_chk(6'd7, 8'(cfg_lo[2][7]), "R9 low entry s2 c7");
    rd_chk(6'd11, 8'(cfg_lo[2][11]), "R9 low entry s2 c11");

    // R7: global drive enable override
    ode_i = 1'b0;
    repeat (FR / 2) tick();
    ode_i = 1'b1;
    repeat (FR) tick();

    // Config B: all variable delay, source channel at j, j-1 and j+1 (R5 boundary)
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < NCH; j++) begin
        int c;
        c = (j % 3 == 0) ? j : ((j % 3 == 1) ? j - 1 : (j + 1) % NCH);
        cfg_hi[s][j] = {28'd0, j % 2 == 1, 1'b1, 1'b1, 1'b0};
        cfg_lo[s][j] = s * NCH + c;
        bc[s][j] = 1'b0;
      end
    end
    push_cfg();
    repeat (3 * FR) tick();

    // Config C: all constant delay with messages every fourth slot (R4, R2)
    for (int s = 0; s < NS; s++) begin
      for (int j = 0; j < NCH; j++) begin
        cfg_hi[s][j] = {28'd0, 1'b0, 1'b0, 1'b1, j % 4 == 0};
        cfg_lo[s][j] = (j % 4 == 0) ? (255 - j - s) : (NS - 1 - s) * NCH + j;
      end
    end
    push_cfg();
    repeat (3 * FR) tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
      $finish;
    end
  end
endmodule